// File: doc/BRIEF.md
# LCD Four-Level Drive Encoder

This block turns the scan state of a multiplexed LCD into level selections for every drive pin. Each cycle it takes the index of the common line being scanned, the frame polarity, one row of display data and two safety controls. From them it produces a 2-bit level code for each common pin and each segment pin. An external analog switch uses each code to connect its pin to one of four bias voltages.

Common pins and segment pins use different pairs of intermediate levels, and the two share one code space. On a common pin, code 01 means V4 and code 10 means V1. On a segment pin, code 01 means V3 and code 10 means V2. Code 00 always means ground and code 11 always means the top drive rail. Frame B is the mirror of frame A, which keeps the average voltage across the panel at zero. A blank input turns off every segment while the commons keep scanning. A force-off input puts the whole panel into a static safe state and overrides blank.

All codes leave through one register stage, so every pin changes on the same clock edge.

Top module: `lcd_drive_enc`

## Requirements
- R1: While rst_n is low, every common code and every segment code is 01, whatever the other inputs are.
- R2: In frame A (frame_b=0), with force_off low, the common pin whose number equals com_idx gets code 11 and every other common pin gets code 01.
- R3: In frame B (frame_b=1), with force_off low, the selected common pin gets code 00 and every other common pin gets code 10.
- R4: In frame A, with blank and force_off low, segment i gets code 00 when row_data[i] is 1 and code 10 when row_data[i] is 0.
- R5: In frame B, with blank and force_off low, segment i gets code 11 when row_data[i] is 1 and code 01 when row_data[i] is 0.
- R6: While blank is high and force_off is low, every segment gets the off code of the current frame (10 in frame A, 01 in frame B), whatever row_data holds. The commons still follow R2 and R3.
- R7: While force_off is high, every common and every segment gets code 01, whatever blank, frame_b, com_idx and row_data are.
- R8: Pin k of an output vector uses bits [2k+1:2k]. A change on any input shows up on all pins at the first rising clock edge after the change, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; sets every pin to code 01 |
| force_off | input | 1 | Static safe state: V4 on commons, V3 on segments |
| blank | input | 1 | Turns all segments off while the commons keep scanning |
| frame_b | input | 1 | Frame polarity: 0 selects frame A, 1 selects frame B |
| com_idx | input | 3 | Number of the common line being scanned |
| row_data | input | 64 | Row of display data; bit i drives segment i, and 1 turns the segment on |
| com_lvl | output | 16 | Registered level codes, 2 bits per common pin |
| seg_lvl | output | 128 | Registered level codes, 2 bits per segment pin |

## Verification
Every result appears exactly one clock edge after the inputs that cause it. The bench applies inputs on the falling edge and compares both output vectors on the next falling edge, so exactly one rising edge has passed between stimulus and check. For R8, the bench changes the inputs and samples again a nanosecond before the next rising edge, where the old codes must still be present. The bound checker keeps a one-cycle copy of the inputs, so each of its properties compares the outputs with the stimulus of the previous edge.

// File: rtl/lcd_lvl_pkg.sv
`timescale 1ns/1ps
package lcd_lvl_pkg;

    // Shared level code space; the meaning of the two middle codes
    // depends on whether the pin is a common or a segment.
    localparam logic [1:0] LVL_GND  = 2'b00;
    localparam logic [1:0] LVL_LOW  = 2'b01;
    localparam logic [1:0] LVL_HIGH = 2'b10;
    localparam logic [1:0] LVL_TOP  = 2'b11;

    // Frame B mirrors frame A: bitwise inversion of the code.
    function automatic logic [1:0] polar(input logic [1:0] a_code, input logic fb);
        return a_code ^ {fb, fb};
    endfunction

endpackage

// File: rtl/lcd_com_enc.sv
`timescale 1ns/1ps
module lcd_com_enc #(
    parameter int NUM_COM = 8,
    parameter int IDX_W   = $clog2(NUM_COM)
) (
    input  logic [IDX_W-1:0]     idx,
    input  logic                 frame_b,
    input  logic                 force_off,
    output logic [2*NUM_COM-1:0] lvl
);
    import lcd_lvl_pkg::*;

    for (genvar k = 0; k < NUM_COM; k++) begin : g_com
        logic [1:0] a_code;
        always_comb begin
            a_code = (idx == IDX_W'(k)) ? LVL_TOP : LVL_LOW;
            if (force_off)
                lvl[2*k +: 2] = LVL_LOW;
            else
                lvl[2*k +: 2] = polar(a_code, frame_b);
        end
    end

endmodule

// File: rtl/lcd_seg_enc.sv
`timescale 1ns/1ps
module lcd_seg_enc #(
    parameter int NUM_SEG = 64
) (
    input  logic [NUM_SEG-1:0]   row,
    input  logic                 frame_b,
    input  logic                 blank,
    input  logic                 force_off,
    output logic [2*NUM_SEG-1:0] lvl
);
    import lcd_lvl_pkg::*;

    for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
        logic [1:0] a_code;
        always_comb begin
            a_code = (row[i] && !blank) ? LVL_GND : LVL_HIGH;
            if (force_off)
                lvl[2*i +: 2] = LVL_LOW;
            else
                lvl[2*i +: 2] = polar(a_code, frame_b);
        end
    end

endmodule

// File: rtl/lcd_drive_enc.sv
`timescale 1ns/1ps
module lcd_drive_enc #(
    parameter int NUM_COM = 8,
    parameter int NUM_SEG = 64,
    localparam int IDX_W  = $clog2(NUM_COM),
    localparam int COM_W  = 2 * NUM_COM,
    localparam int SEG_W  = 2 * NUM_SEG
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               force_off,
    input  logic               blank,
    input  logic               frame_b,
    input  logic [IDX_W-1:0]   com_idx,
    input  logic [NUM_SEG-1:0] row_data,
    output logic [COM_W-1:0]   com_lvl,
    output logic [SEG_W-1:0]   seg_lvl
);
    import lcd_lvl_pkg::*;

    typedef struct packed {
        logic [COM_W-1:0] com;
        logic [SEG_W-1:0] seg;
    } drv_t;

    drv_t st_d, st_q;
    logic [COM_W-1:0] com_next;
    logic [SEG_W-1:0] seg_next;

    lcd_com_enc #(.NUM_COM(NUM_COM), .IDX_W(IDX_W)) u_com (
        .idx       (com_idx),
        .frame_b   (frame_b),
        .force_off (force_off),
        .lvl       (com_next)
    );

    lcd_seg_enc #(.NUM_SEG(NUM_SEG)) u_seg (
        .row       (row_data),
        .frame_b   (frame_b),
        .blank     (blank),
        .force_off (force_off),
        .lvl       (seg_next)
    );

    always_comb begin
        st_d     = st_q;
        st_d.com = com_next;
        st_d.seg = seg_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.com <= {NUM_COM{LVL_LOW}};
            st_q.seg <= {NUM_SEG{LVL_LOW}};
        end else begin
            st_q <= st_d;
        end
    end

    assign com_lvl = st_q.com;
    assign seg_lvl = st_q.seg;

endmodule

// File: rtl/lcd_drive_enc_chk.sv
`timescale 1ns/1ps
module lcd_drive_enc_chk #(
    parameter int NUM_COM = 8,
    parameter int NUM_SEG = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 force_off,
    input logic                 blank,
    input logic                 frame_b,
    input logic [NUM_SEG-1:0]   row_data,
    input logic [2*NUM_COM-1:0] com_lvl,
    input logic [2*NUM_SEG-1:0] seg_lvl
);
    logic               p_valid, p_force, p_blank, p_fb;
    logic [NUM_SEG-1:0] p_row;
    int sel_cnt, unsel_cnt, on_cnt, off_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_valid <= 1'b0;
            p_force <= 1'b0;
            p_blank <= 1'b0;
            p_fb    <= 1'b0;
            p_row   <= '0;
        end else begin
            p_valid <= 1'b1;
            p_force <= force_off;
            p_blank <= blank;
            p_fb    <= frame_b;
            p_row   <= row_data;
        end
    end

    always_comb begin
        sel_cnt = 0; unsel_cnt = 0; on_cnt = 0; off_cnt = 0;
        for (int k = 0; k < NUM_COM; k++) begin
            if (com_lvl[2*k +: 2] == (p_fb ? 2'b00 : 2'b11)) sel_cnt++;
            if (com_lvl[2*k +: 2] == (p_fb ? 2'b10 : 2'b01)) unsel_cnt++;
        end
        for (int i = 0; i < NUM_SEG; i++) begin
            if (seg_lvl[2*i +: 2] == (p_fb ? 2'b11 : 2'b00)) on_cnt++;
            if (seg_lvl[2*i +: 2] == (p_fb ? 2'b01 : 2'b10)) off_cnt++;
        end
    end

    // R7
    force_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_valid && p_force) |->
        (com_lvl == {NUM_COM{2'b01}} && seg_lvl == {NUM_SEG{2'b01}}));

    // R6
    blank_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_valid && p_blank && !p_force) |->
        (seg_lvl == {NUM_SEG{(p_fb ? 2'b01 : 2'b10)}}));

    // R2 R3
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_valid && !p_force) |-> (sel_cnt == 1 && unsel_cnt == NUM_COM - 1));

    // R4 R5
    seg_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_valid && !p_force && !p_blank) |->
        (on_cnt == $countones(p_row) && off_cnt == NUM_SEG - on_cnt));

endmodule

bind lcd_drive_enc lcd_drive_enc_chk #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .force_off (force_off),
    .blank     (blank),
    .frame_b   (frame_b),
    .row_data  (row_data),
    .com_lvl   (com_lvl),
    .seg_lvl   (seg_lvl)
);

// File: tb/lcd_drive_enc_bench.sv
`timescale 1ns/1ps
module lcd_drive_enc_bench;
    localparam int NC = 8;
    localparam int NS = 64;
    localparam int NV = 11;

    typedef struct packed {
        logic        frc;
        logic        blk;
        logic        fb;
        logic [2:0]  idx;
        logic [63:0] row;
        logic [1:0]  e_sel;
        logic [1:0]  e_uns;
        logic [1:0]  e_on;
        logic [1:0]  e_off;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,1'b0,3'd0,64'hA5A5_A5A5_A5A5_A5A5,2'b11,2'b01,2'b00,2'b10},
        '{1'b0,1'b0,1'b1,3'd0,64'hA5A5_A5A5_A5A5_A5A5,2'b00,2'b10,2'b11,2'b01},
        '{1'b0,1'b0,1'b0,3'd7,64'h8000_0000_0000_0001,2'b11,2'b01,2'b00,2'b10},
        '{1'b0,1'b0,1'b1,3'd7,64'h0123_4567_89AB_CDEF,2'b00,2'b10,2'b11,2'b01},
        '{1'b0,1'b0,1'b0,3'd3,64'hFFFF_FFFF_FFFF_FFFF,2'b11,2'b01,2'b00,2'b10},
        '{1'b0,1'b0,1'b1,3'd5,64'h0,                  2'b00,2'b10,2'b11,2'b01},
        '{1'b0,1'b1,1'b0,3'd2,64'hFFFF_FFFF_FFFF_FFFF,2'b11,2'b01,2'b10,2'b10},
        '{1'b0,1'b1,1'b1,3'd6,64'hFFFF_FFFF_FFFF_FFFF,2'b00,2'b10,2'b01,2'b01},
        '{1'b1,1'b0,1'b0,3'd4,64'hFFFF_FFFF_FFFF_FFFF,2'b01,2'b01,2'b01,2'b01},
        '{1'b1,1'b1,1'b1,3'd1,64'hA5A5_A5A5_A5A5_A5A5,2'b01,2'b01,2'b01,2'b01},
        '{1'b0,1'b1,1'b0,3'd0,64'h0,                  2'b11,2'b01,2'b10,2'b10}
    };

    localparam string TAG [NV] = '{"R2 R4", "R3 R5", "R2 R4", "R3 R5", "R4",
                                  "R5", "R6", "R6", "R7", "R7", "R6"};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          force_off = 1'b0, blank = 1'b0, frame_b = 1'b0;
    logic [2:0]    com_idx = '0;
    logic [NS-1:0] row_data = '0;
    logic [2*NC-1:0] com_lvl;
    logic [2*NS-1:0] seg_lvl;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lcd_drive_enc u_lcd_drive_enc (
        .clk(clk), .rst_n(rst_n), .force_off(force_off), .blank(blank),
        .frame_b(frame_b), .com_idx(com_idx), .row_data(row_data),
        .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    function automatic logic [2*NC-1:0] mk_com(input vec_t v);
        logic [2*NC-1:0] r;
        for (int k = 0; k < NC; k++) r[2*k +: 2] = (v.idx == 3'(k)) ? v.e_sel : v.e_uns;
        return r;
    endfunction

    function automatic logic [2*NS-1:0] mk_seg(input vec_t v);
        logic [2*NS-1:0] r;
        for (int i = 0; i < NS; i++) r[2*i +: 2] = v.row[i] ? v.e_on : v.e_off;
        return r;
    endfunction

    task automatic check_com(input string tag, input logic [2*NC-1:0] exp_v);
        total++;
        if (com_lvl !== exp_v) begin
            bad++;
            $display("FAIL %s com_lvl actual=%h expected=%h", tag, com_lvl, exp_v);
        end
    endtask

    task automatic check_seg(input string tag, input logic [2*NS-1:0] exp_v);
        total++;
        if (seg_lvl !== exp_v) begin
            bad++;
            $display("FAIL %s seg_lvl actual=%h expected=%h", tag, seg_lvl, exp_v);
        end
    endtask

    task automatic apply(input vec_t v);
        force_off = v.frc; blank = v.blk; frame_b = v.fb;
        com_idx = v.idx; row_data = v.row;
    endtask

    initial begin
        #100000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset holds safe codes against active-looking inputs
        apply(VEC[0]);
        repeat (3) @(negedge clk);
        check_com("R1", {NC{2'b01}});
        check_seg("R1", {NS{2'b01}});
        @(negedge clk);
        rst_n = 1'b1;

        // table walk: one rising edge between stimulus and check
        for (int n = 0; n < NV; n++) begin
            apply(VEC[n]);
            @(negedge clk);
            check_com(TAG[n], mk_com(VEC[n]));
            check_seg(TAG[n], mk_seg(VEC[n]));
        end

        // R8: no change before the edge, all pins change on it
        apply(VEC[0]);
        @(negedge clk);
        apply(VEC[3]);
        @(posedge clk);
        #0;
        @(negedge clk);
        apply(VEC[1]);
        #1;
        check_com("R8 before edge", mk_com(VEC[3]));
        check_seg("R8 before edge", mk_seg(VEC[3]));
        @(negedge clk);
        check_com("R8 after edge", mk_com(VEC[1]));
        check_seg("R8 after edge", mk_seg(VEC[1]));

        // R7 release: back to normal scanning on the next edge
        apply(VEC[9]);
        @(negedge clk);
        apply(VEC[2]);
        @(negedge clk);
        check_com("R7 release", mk_com(VEC[2]));
        check_seg("R7 release", mk_seg(VEC[2]));

        // R1: asynchronous reset mid-run
        #0.5 rst_n = 1'b0;
        #0.5;
        check_com("R1 async", {NC{2'b01}});
        check_seg("R1 async", {NS{2'b01}});

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule